// File: doc/BRIEF.md
# External Bus Request/Grant Arbiter

This block decides who drives the external memory bus: the local processor or an outside master. The outside master raises an asynchronous request line. The arbiter synchronizes that line, then lets any external access already under way run to completion. Once the bus is idle, it switches off the address, data, memory-select and strobe drivers, asserts grant, and stops the processor from starting new external accesses.

By default the processor halts as soon as the bus is handed over. With continue mode enabled, the processor keeps running until an instruction needs the external bus. A stall flag reports that the processor is ready to go but blocked by the outstanding grant.

When the request drops, grant falls first. The drivers return a programmable number of cycles later, so that two masters never drive the bus at once, and the blocked access then proceeds. The arbiter keeps serving requests while the processor is held in reset or is loading its boot image.

Top module: `xbus_arbiter`

## Requirements
- R1: A change on `ext_req` passes through two synchronizer flops. With the bus idle, `bus_grant` rises on the third rising clock edge after `ext_req` rises.
- R2: `bus_oe` falls on the same edge on which `bus_grant` rises. `bus_oe` and `bus_grant` are never high together.
- R3: While `xacc_busy` is high, grant is not given. `bus_grant` rises only on an edge that follows a cycle with `xacc_busy` low.
- R4: `xacc_go` is low whenever a synchronized request is pending or the bus is not owned. An instruction with two external accesses is therefore split by a grant. A processor that needs the bus while `xacc_go` is low has `core_run` low.
- R5: With `go_mode` low, `core_run` is low for as long as the bus is not owned.
- R6: With `go_mode` high, `core_run` stays high while granted as long as `xacc_need` is low. It drops in the cycle in which `xacc_need` rises.
- R7: `grant_hung` is high exactly when `bus_grant` and `xacc_need` are both high. It falls with grant on release.
- R8: After `ext_req` falls, `bus_grant` falls on the third edge. `bus_oe` returns RETURN_GAP edges later (default 1) and stays low in between.
- R9: While `core_boot` is high, `core_run` is low. The grant and release timing is unchanged.
- R10: After reset, `bus_oe`=1, `bus_grant`=0, `grant_hung`=0, and `xacc_go`=1 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset of the arbiter flops |
| ext_req | input | 1 | Asynchronous bus request from the outside master, active high |
| go_mode | input | 1 | 1 = processor keeps executing while granted until it needs the bus |
| core_boot | input | 1 | Processor held in reset or booting; no instruction execution |
| xacc_busy | input | 1 | An external access (including wait states) is in progress this cycle |
| xacc_need | input | 1 | The processor wants to start an external access |
| bus_oe | output | 1 | Enable for address, data, memory-select and strobe drivers |
| bus_grant | output | 1 | Bus handed to the outside master |
| grant_hung | output | 1 | Processor ready but blocked by the grant |
| core_run | output | 1 | Processor may execute this cycle |
| xacc_go | output | 1 | Processor may start its pending external access |

## Verification
The checker watches four things on every cycle. It checks that grant and driver enable are exclusive and switch on the same edge, and that grant never follows a busy cycle. It also checks that no access can start while the bus is not owned, and that the stall flag and the halt are consistent with the mode inputs and `core_boot`. Only the bench scenarios can show the exact latencies: the three-edge synchronizer delay on request and release, the wait for a long access to end, and the one-cycle gap before the drivers return. The bench's per-cycle reference model covers all of these.

// File: rtl/xbus_arb_pkg.sv
// Shared types for the external bus arbiter.
// Assumes: a single owner state machine; encodings are local to this block.
package xbus_arb_pkg;

    // Bus ownership phase
    typedef enum logic [1:0] {
        XB_OWN    = 2'd0,   // local processor drives the bus
        XB_GRANT  = 2'd1,   // outside master owns the bus
        XB_RETURN = 2'd2    // grant dropped, drivers still off
    } xb_state_e;

endpackage

// File: rtl/xbus_req_sync.sv
// Request synchronizer: carries the asynchronous request into the clock
// domain through a chain of STAGES flops.
// Assumes: STAGES >= 1; the input may change at any time.
module xbus_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_sync
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first flop samples the raw request
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= req_async;
                end
            end else begin : g_next
                // later flops shift the sample along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign req_sync = chain[STAGES-1];

endmodule

// File: rtl/xbus_grant_fsm.sv
// Ownership state machine: hands the bus over once it is idle and a
// synchronized request is present. On release it holds the drivers off
// for GAP cycles after grant falls.
// Assumes: acc_busy covers every cycle of an external access; GAP >= 1.
module xbus_grant_fsm
    import xbus_arb_pkg::*;
#(
    parameter int GAP = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_sync,
    input  logic      acc_busy,
    output xb_state_e state,
    output logic      drv_oe,
    output logic      grant
);

    localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP - 1);

    xb_state_e        state_q, state_d;
    logic [GAP_W-1:0] gap_q, gap_d;

    // next-state decision for the ownership phase
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            XB_OWN: begin
                gap_d = '0;
                if (req_sync && !acc_busy) state_d = XB_GRANT;
            end
            XB_GRANT: begin
                gap_d = '0;
                if (!req_sync) state_d = XB_RETURN;
            end
            XB_RETURN: begin
                if (gap_q == GAP_LAST) begin
                    state_d = XB_OWN;
                    gap_d   = '0;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
            default: state_d = XB_OWN;
        endcase
    end

    // state and gap counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XB_OWN;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // registered driver enable and grant, switched on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_oe <= 1'b1;
            grant  <= 1'b0;
        end else begin
            drv_oe <= (state_d == XB_OWN);
            grant  <= (state_d == XB_GRANT);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/xbus_core_gate.sv
// Processor gating: decides whether the processor may execute and whether
// it may start an external access, and raises the stall flag.
// Assumes: acc_need is the processor's wish for the bus in this cycle.
module xbus_core_gate
    import xbus_arb_pkg::*;
(
    input  xb_state_e state,
    input  logic      grant,
    input  logic      req_sync,
    input  logic      acc_need,
    input  logic      go_mode,
    input  logic      core_boot,
    output logic      acc_go,
    output logic      core_run,
    output logic      grant_hung
);

    logic owned;
    logic may_run;

    // access start allowed only on an owned bus with no request pending
    always_comb begin
        owned  = (state == XB_OWN);
        acc_go = owned && !req_sync;
    end

    // execution permission per phase and mode
    always_comb begin
        if (owned)        may_run = !(acc_need && !acc_go);
        else if (go_mode) may_run = !acc_need;
        else              may_run = 1'b0;
        core_run = may_run && !core_boot;
    end

    // stall flag: processor wants the bus the master currently holds
    always_comb begin
        grant_hung = grant && acc_need;
    end

endmodule

// File: rtl/xbus_arbiter.sv
// External bus request/grant arbiter, top level. It synchronizes the outside
// request, runs the ownership state machine and gates the processor.
// Assumes: the processor core and memory timing sit outside; core_boot only
// affects execution, never request handling.
module xbus_arbiter
    import xbus_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RETURN_GAP  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic go_mode,
    input  logic core_boot,
    input  logic xacc_busy,
    input  logic xacc_need,
    output logic bus_oe,
    output logic bus_grant,
    output logic grant_hung,
    output logic core_run,
    output logic xacc_go
);

    logic      req_s;
    xb_state_e st;

    xbus_req_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (ext_req),
        .req_sync  (req_s)
    );

    xbus_grant_fsm #(
        .GAP (RETURN_GAP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_sync (req_s),
        .acc_busy (xacc_busy),
        .state    (st),
        .drv_oe   (bus_oe),
        .grant    (bus_grant)
    );

    xbus_core_gate u_gate (
        .state      (st),
        .grant      (bus_grant),
        .req_sync   (req_s),
        .acc_need   (xacc_need),
        .go_mode    (go_mode),
        .core_boot  (core_boot),
        .acc_go     (xacc_go),
        .core_run   (core_run),
        .grant_hung (grant_hung)
    );

endmodule

// File: rtl/xbus_arbiter_chk.sv
// Property checker for the arbiter, attached by bind.
// Assumes: sampled on the arbiter clock with its synchronous reset.
module xbus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic go_mode,
    input logic core_boot,
    input logic xacc_busy,
    input logic xacc_need,
    input logic bus_oe,
    input logic bus_grant,
    input logic grant_hung,
    input logic core_run,
    input logic xacc_go
);

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_grant && bus_oe));

    p_same_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $fell(bus_oe));

    p_wait_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> !$past(xacc_busy));

    p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> !xacc_go);

    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe && !go_mode) |-> !core_run);

    p_continue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && go_mode && !xacc_need && !core_boot) |-> core_run);

    p_hung_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hung |-> (bus_grant && xacc_need));

    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant) |-> !bus_oe);

    p_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_boot |-> !core_run);

endmodule

bind xbus_arbiter xbus_arbiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_mode    (go_mode),
    .core_boot  (core_boot),
    .xacc_busy  (xacc_busy),
    .xacc_need  (xacc_need),
    .bus_oe     (bus_oe),
    .bus_grant  (bus_grant),
    .grant_hung (grant_hung),
    .core_run   (core_run),
    .xacc_go    (xacc_go)
);

// File: tb/xbus_arbiter_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed
// checks for each requirement.
module xbus_arbiter_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 1'b0, go_mode = 1'b0, core_boot = 1'b0;
    logic xacc_busy = 1'b0, xacc_need = 1'b0;
    logic bus_oe, bus_grant, grant_hung, core_run, xacc_go;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xbus_arbiter u_xbus_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .go_mode(go_mode),
        .core_boot(core_boot), .xacc_busy(xacc_busy), .xacc_need(xacc_need),
        .bus_oe(bus_oe), .bus_grant(bus_grant), .grant_hung(grant_hung),
        .core_run(core_run), .xacc_go(xacc_go)
    );

    // reference model: request delay queue and phase integer (0 own, 1 granted, 2 gap)
    bit sync_q[$];
    int m_ph = 0;

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            sync_q = '{1'b0, 1'b0};
            m_ph = 0;
        end else begin
            if (m_ph == 0) begin
                if (sync_q[0] && !xacc_busy) m_ph = 1;
            end else if (m_ph == 1) begin
                if (!sync_q[0]) m_ph = 2;
            end else begin
                m_ph = 0;
            end
            sync_q.push_back(ext_req);
            void'(sync_q.pop_front());
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            logic e_oe, e_gr, e_go, e_hung, e_run;
            e_oe   = (m_ph == 0);
            e_gr   = (m_ph == 1);
            e_go   = e_oe && !sync_q[0];
            e_hung = e_gr && xacc_need;
            if (e_oe)         e_run = !(xacc_need && !e_go);
            else if (go_mode) e_run = !xacc_need;
            else              e_run = 1'b0;
            e_run = e_run && !core_boot;
            check(bus_oe,     e_oe,   "R2 model bus_oe");
            check(bus_grant,  e_gr,   "R1 model bus_grant");
            check(xacc_go,    e_go,   "R4 model xacc_go");
            check(grant_hung, e_hung, "R7 model grant_hung");
            check(core_run,   e_run,  "R5 model core_run");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        check(bus_oe, 1'b1, "R10 oe after reset");
        check(bus_grant, 1'b0, "R10 grant after reset");
        check(grant_hung, 1'b0, "R10 hung after reset");
        check(xacc_go, 1'b1, "R10 go after reset");

        // R1/R2/R5 idle bus, halt mode
        ext_req = 1'b1;
        step(2);
        check(bus_grant, 1'b0, "R1 grant not before third edge");
        step(1);
        check(bus_grant, 1'b1, "R1 grant on third edge");
        check(bus_oe, 1'b0, "R2 drivers off with grant");
        check(core_run, 1'b0, "R5 halted while granted");
        step(4);

        // R8 release timing
        ext_req = 1'b0;
        step(3);
        check(bus_grant, 1'b0, "R8 grant dropped");
        check(bus_oe, 1'b0, "R8 drivers still off in gap");
        check(core_run, 1'b0, "R5 halted in gap");
        step(1);
        check(bus_oe, 1'b1, "R8 drivers back");
        step(2);

        // R3 long access in progress
        xacc_busy = 1'b1;
        ext_req = 1'b1;
        step(5);
        check(bus_grant, 1'b0, "R3 no grant while busy");
        check(xacc_go, 1'b0, "R4 no new start with request pending");
        xacc_busy = 1'b0;
        step(1);
        check(bus_grant, 1'b1, "R3 grant after access ends");
        ext_req = 1'b0;
        step(6);

        // R4/R7 processor wants the bus as request arrives
        xacc_need = 1'b1;
        ext_req = 1'b1;
        step(2);
        check(xacc_go, 1'b0, "R4 start refused with request pending");
        check(core_run, 1'b0, "R4 stalled waiting for start");
        check(bus_grant, 1'b0, "R4 not yet granted");
        step(1);
        check(bus_grant, 1'b1, "R4 grant between accesses");
        check(grant_hung, 1'b1, "R7 hung while needed");
        ext_req = 1'b0;
        step(3);
        check(grant_hung, 1'b0, "R7 hung falls with grant");
        step(1);
        check(xacc_go, 1'b1, "R4 access proceeds after release");
        xacc_need = 1'b0;
        step(2);

        // R6 continue mode
        go_mode = 1'b1;
        ext_req = 1'b1;
        step(3);
        check(bus_grant, 1'b1, "R6 granted");
        check(core_run, 1'b1, "R6 keeps running");
        check(grant_hung, 1'b0, "R7 no hung without need");
        step(2);
        xacc_need = 1'b1;
        #1;
        check(core_run, 1'b0, "R6 stops when bus needed");
        check(grant_hung, 1'b1, "R7 hung in continue mode");
        ext_req = 1'b0;
        step(5);
        xacc_need = 1'b0;
        go_mode = 1'b0;
        step(2);

        // R9 request served while processor in boot
        core_boot = 1'b1;
        ext_req = 1'b1;
        step(3);
        check(bus_grant, 1'b1, "R9 grant during boot");
        check(core_run, 1'b0, "R9 no execution in boot");
        ext_req = 1'b0;
        step(4);
        check(bus_oe, 1'b1, "R9 release during boot");
        core_boot = 1'b0;
        step(2);
        check(core_run, 1'b1, "R9 runs after boot");

        // short request pulse shorter than synchronizer still granted once
        ext_req = 1'b1;
        step(1);
        ext_req = 1'b0;
        step(2);
        check(bus_grant, 1'b1, "R1 one-cycle pulse granted");
        step(4);
        check(bus_oe, 1'b1, "R8 pulse released");
        finish_run();
    end

endmodule